// File: doc/BRIEF.md
# Fifteen-Source Prioritised Interrupt Controller

This block gathers up to fifteen interrupt sources, numbered 1 to 15, into a pending register. It masks that register and presents the highest-numbered unmasked pending source to the processor as a 4-bit interrupt level, together with the matching trap type. A level of zero means no request. A source registers as pending on a rising edge of its input. The bit stays set until software clears it through a register write, or until the processor acknowledges that level.

Software reaches the block through a simple word-wide register port with a write strobe, an 8-bit byte offset and a combinational read path. The port gives read access to the pending bits and read/write access to the mask. It also has a write-only clear word and a write-only force word. Force writes act only while a test-enable bit is set in a separate test-control word, so normal software cannot inject interrupts by mistake. Source n always uses bit n of every vector word, and bit 0 is never used.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, pending reads 0x0000, mask reads 0xFFFE (every source blocked), test control reads 0, and the level and trap outputs are 0.
- R2: A 0-to-1 transition on source input n sets pending bit n. The bit is visible on the next rising clock edge. A source held high does not set the bit again once it has been cleared.
- R3: The level output equals the highest n for which pending bit n is 1 and mask bit n is 0. When no such n exists, the level output is 0.
- R4: Mask bit n equal to 1 keeps source n out of the level output, while its pending bit is still captured and readable. The mask word is written and read at offset 0x4C.
- R5: A write to offset 0x50 clears every pending bit whose position holds 1 in the written word. All other pending bits are left unchanged.
- R6: A write to offset 0x54 sets the pending bits marked by 1s in the word, but only while bit 19 of the test-control word (offset 0xD0) is 1. Otherwise the write leaves pending unchanged.
- R7: The trap type output equals the level plus 0x10 when the level is nonzero, and 0 when the level is 0.
- R8: An acknowledge with a level L from 1 to 15 clears pending bit L on that clock edge. An acknowledge with level 0 changes nothing.
- R9: If a source edge for bit n coincides with a clear write or an acknowledge of bit n, the bit ends up set.
- R10: Bit 0 always reads 0 in the pending and mask words. Writing 1 to bit 0 through force or mask has no effect.
- R11: Pending reads at offset 0x48 and test control at offset 0xD0 (only bit 19 is stored). Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 15 | Source inputs, bit n is source n (index 15:1) |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, combinational from the offset |
| ack_valid_i | input | 1 | Level acknowledge strobe |
| ack_level_i | input | 4 | Level being acknowledged |
| irq_level_o | output | 4 | Highest unmasked pending source, 0 when none |
| trap_type_o | output | 8 | Level plus 0x10, or 0 when idle |

## Verification
The bench sweeps every single-source position and several hundred generated pending and mask pairs, and computes the expected level as the top set bit of pending AND NOT mask. An encoder that picked the lowest bit, or that ignored the mask, would miscompare at once. It forces bits with the test gate off, where a missing gate would show up as spurious pending bits. It also fires a source edge in the same cycle as a clear or an acknowledge of that bit, where a design that lets the clear win loses the event. A held-high source after a clear, a level-0 acknowledge and writes to bit 0 check that level-triggered capture, a stray clear and a phantom source 0 each show up on the read port.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int TRAP_W    = 8;
  localparam int TEST_BIT  = 19;
  localparam logic [ADDR_W-1:0] OFF_PEND = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_MASK = 8'h4C;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_FRC  = 8'h54;
  localparam logic [ADDR_W-1:0] OFF_TST  = 8'hD0;
  localparam logic [TRAP_W-1:0] TRAP_BASE = 8'h10;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int NUM_SRC = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC:1]   src_i,
  output logic [NUM_SRC:0]   rise_o
);
  assign rise_o[0] = 1'b0;

  for (genvar i = 1; i <= NUM_SRC; i++) begin : g_bit
    logic src_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) src_q <= 1'b0;
      else         src_q <= src_i[i];
    end
    assign rise_o[i] = src_i[i] & ~src_q;
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_SRC = 15,
  parameter int LVL_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC:0]   set_i,
  input  logic [NUM_SRC:0]   clr_i,
  input  logic               ack_valid_i,
  input  logic [LVL_W-1:0]   ack_lvl_i,
  output logic [NUM_SRC:0]   pend_o
);
  assign pend_o[0] = 1'b0;

  for (genvar i = 1; i <= NUM_SRC; i++) begin : g_bit
    logic pend_q;
    logic ack_hit;
    assign ack_hit = ack_valid_i && (ack_lvl_i == LVL_W'(i));
    // set has priority so no edge is dropped
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   pend_q <= 1'b0;
      else if (set_i[i])             pend_q <= 1'b1;
      else if (clr_i[i] || ack_hit)  pend_q <= 1'b0;
    end
    assign pend_o[i] = pend_q;
  end

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

  // R8
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_valid_i && ack_lvl_i != '0 && int'(ack_lvl_i) <= NUM_SRC && !set_i[ack_lvl_i])
      |=> !pend_o[$past(ack_lvl_i)]);

  // R5
  clr_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0 && set_i == '0) |=> ((pend_o & $past(clr_i)) == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_SRC = 15,
  parameter int LVL_W   = 4
) (
  input  logic [NUM_SRC:0]  req_i,
  output logic [LVL_W-1:0]  lvl_o
);
  always_comb begin
    lvl_o = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (req_i[i]) lvl_o = LVL_W'(i);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import ic_pkg::*;
#(
  parameter int NUM_SRC = 15,
  localparam int LVL_W  = $clog2(NUM_SRC + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC:1]    src_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic                ack_valid_i,
  input  logic [LVL_W-1:0]    ack_level_i,
  output logic [LVL_W-1:0]    irq_level_o,
  output logic [TRAP_W-1:0]   trap_type_o
);
  logic [NUM_SRC:0] rise_vec, set_vec, clr_vec, pend_vec, mask_full, req_vec;
  logic [NUM_SRC:1] mask_q;
  logic             test_en_q;
  logic             wr_mask, wr_clr, wr_frc, wr_tst;

  assign wr_mask = bus_we_i && (bus_addr_i == OFF_MASK);
  assign wr_clr  = bus_we_i && (bus_addr_i == OFF_CLR);
  assign wr_frc  = bus_we_i && (bus_addr_i == OFF_FRC);
  assign wr_tst  = bus_we_i && (bus_addr_i == OFF_TST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= '1;
      test_en_q <= 1'b0;
    end else begin
      if (wr_mask) mask_q    <= bus_wdata_i[NUM_SRC:1];
      if (wr_tst)  test_en_q <= bus_wdata_i[TEST_BIT];
    end
  end

  irq_edge_det #(.NUM_SRC(NUM_SRC)) edge_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .rise_o(rise_vec)
  );

  always_comb begin
    set_vec = rise_vec;
    if (wr_frc && test_en_q) set_vec = set_vec | {bus_wdata_i[NUM_SRC:1], 1'b0};
    clr_vec = wr_clr ? bus_wdata_i[NUM_SRC:0] : '0;
  end

  irq_pend_bank #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) bank_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_vec), .clr_i(clr_vec),
    .ack_valid_i(ack_valid_i), .ack_lvl_i(ack_level_i), .pend_o(pend_vec)
  );

  assign mask_full = {mask_q, 1'b0};
  assign req_vec   = pend_vec & ~mask_full;

  irq_prio_enc #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) enc_i (
    .req_i(req_vec), .lvl_o(irq_level_o)
  );

  assign trap_type_o = (irq_level_o == '0) ? '0 : TRAP_W'(irq_level_o) + TRAP_BASE;

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      OFF_PEND: bus_rdata_o = DATA_W'(pend_vec);
      OFF_MASK: bus_rdata_o = DATA_W'(mask_full);
      OFF_TST:  bus_rdata_o[TEST_BIT] = test_en_q;
      default:  bus_rdata_o = '0;
    endcase
  end

  // R3
  lvl_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_o != '0) |-> (pend_vec[irq_level_o] && !mask_q[irq_level_o]));

  // R3
  lvl_highest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_vec >> irq_level_o) >> 1) == '0);

  // R6
  frc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_frc && !test_en_q && rise_vec == '0) |=> ((pend_vec & ~$past(pend_vec)) == '0));

  // R7
  trap_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_o == '0) |-> (trap_type_o == '0));
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:1] src = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack_v = 1'b0;
  logic [3:0]  ack_l = '0;
  logic [3:0]  lvl;
  logic [7:0]  trap;
  int vectors = 0;
  int fails = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ack_valid_i(ack_v),
    .ack_level_i(ack_l), .irq_level_o(lvl), .trap_type_o(trap)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic logic [3:0] top_bit(input logic [15:0] v);
    logic [3:0] r = '0;
    for (int i = 1; i < 16; i++) if (v[i]) r = 4'(i);
    return r;
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h48, d); chk("R1 pend", d, 32'h0);
    rd(8'h4C, d); chk("R1 mask", d, 32'hFFFE);
    rd(8'hD0, d); chk("R1 test", d, 32'h0);
    chk("R1 level", 32'(lvl), 32'h0);
    chk("R1 trap", 32'(trap), 32'h0);
    // R6 force gated off
    wr(8'h54, 32'hFFFE);
    rd(8'h48, d); chk("R6 gated force", d, 32'h0);
    wr(8'hD0, 32'h0008_0000);
    rd(8'hD0, d); chk("R11 test rd", d, 32'h0008_0000);
    rd(8'h44, d); chk("R11 unmapped", d, 32'h0);
    // R10 bit 0
    wr(8'h4C, 32'hFFFF);
    rd(8'h4C, d); chk("R10 mask b0", d, 32'hFFFE);
    wr(8'h54, 32'h1);
    rd(8'h48, d); chk("R10 force b0", d, 32'h0);
    wr(8'h4C, 32'h0);
    rd(8'h4C, d); chk("R4 mask wr", d, 32'h0);
    // single-source sweep: R3 R5 R6 R7
    for (int n = 1; n < 16; n++) begin
      wr(8'h54, 32'(1) << n);
      chk("R3 single level", 32'(lvl), 32'(n));
      chk("R7 trap", 32'(trap), 32'(n + 16));
      wr(8'h50, 32'(1) << n);
      rd(8'h48, d); chk("R5 clear single", d, 32'h0);
    end
    // pattern sweep: R3 R4 R5
    for (int k = 0; k < 300; k++) begin
      logic [15:0] p, m;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      p = lfsr & 16'hFFFE;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      m = lfsr;
      wr(8'h50, 32'hFFFF);
      wr(8'h54, 32'(p));
      wr(8'h4C, 32'(m));
      rd(8'h48, d); chk("R4 pend kept", d, 32'(p));
      chk("R3 pattern level", 32'(lvl), 32'(top_bit(p & ~m)));
      wr(8'h50, 32'(m));
      rd(8'h48, d); chk("R5 partial clear", d, 32'(p & ~m));
    end
    wr(8'h50, 32'hFFFF);
    wr(8'h4C, 32'h0);
    // R2 edge capture
    @(negedge clk); src[7] = 1'b1;
    @(negedge clk);
    rd(8'h48, d); chk("R2 edge set", d, 32'h80);
    chk("R2 edge level", 32'(lvl), 32'd7);
    wr(8'h50, 32'h80);
    repeat (3) @(negedge clk);
    rd(8'h48, d); chk("R2 held no reset", d, 32'h0);
    src[7] = 1'b0; @(negedge clk);
    src[7] = 1'b1; @(negedge clk);
    rd(8'h48, d); chk("R2 second edge", d, 32'h80);
    src[7] = 1'b0;
    wr(8'h50, 32'hFFFF);
    // R8 acknowledge
    wr(8'h54, 32'h1010);
    chk("R8 pre level", 32'(lvl), 32'd12);
    @(negedge clk); ack_v = 1'b1; ack_l = 4'd12;
    @(negedge clk); ack_v = 1'b0;
    chk("R8 ack level", 32'(lvl), 32'd4);
    @(negedge clk); ack_v = 1'b1; ack_l = 4'd0;
    @(negedge clk); ack_v = 1'b0;
    rd(8'h48, d); chk("R8 ack zero", d, 32'h10);
    wr(8'h50, 32'hFFFF);
    // R9 set wins over clear and ack
    @(negedge clk); src[9] = 1'b1; we = 1'b1; addr = 8'h50; wdata = 32'h200;
    @(negedge clk); we = 1'b0;
    rd(8'h48, d); chk("R9 edge vs clear", d, 32'h200);
    wr(8'h50, 32'hFFFF);
    @(negedge clk); src[10] = 1'b1; ack_v = 1'b1; ack_l = 4'd10;
    @(negedge clk); ack_v = 1'b0;
    rd(8'h48, d); chk("R9 edge vs ack", d, 32'h400);
    // R6 gate off again
    wr(8'h50, 32'hFFFF);
    wr(8'hD0, 32'h0);
    wr(8'h54, 32'h8000);
    rd(8'h48, d); chk("R6 force after disable", d, 32'h0);
    chk("R7 idle trap", 32'(trap), 32'h0);
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule